// File: doc/BRIEF.md
# Per-Channel Analog Watchdog Unit

The unit sits beside a converter sequencer and checks every conversion result against a programmable window. A result is treated as an event when it lies strictly under the lower bound or strictly over the upper bound. In single and non-buffered continuous operation the unit raises one global flag. In scan and buffered operation it keeps one sticky status bit for each sequence entry, and a per-entry mask chooses which entries are checked. The global flag is then raised either when the sequence ends or at once, depending on the two interrupt enables taken together. In the second case a stop pulse also tells the sequencer to halt.

Software reaches the unit through a byte-wide register port with a combinational read path. Flags are cleared only by writing 0 to them. The sequencer supplies a result strobe, the result value, the entry index, an end-of-sequence strobe and a mode bit. It receives the stop request in return.

Top module: `awd_unit`

## Requirements
- R1: After reset, the upper bound reads as 0x3FF (address 1 reads 0xFF, address 2 reads 0x03) and the lower bound reads as 0. Control (address 0), status (addresses 5–6) and mask (addresses 7–8) read 0. `wd_flag`, `wd_irq`, `stop_req` and `wd_status` are 0.
- R2: A result is out of range only when it is strictly less than the lower bound or strictly greater than the upper bound. A result equal to either bound is not an event.
- R3: Each 10-bit bound is written in two bytes. The upper bound's bits 9:2 sit at address 1 and its bits 1:0 at address 2 bits 1:0. The lower bound uses addresses 3 and 4 in the same way. Both read back as written.
- R4: With `mode_multi`=0 and the single-watchdog enable (control bit 3) set, an out-of-range result sets `wd_flag` at the clock edge that samples `res_vld`. With control bit 3 clear, a single-mode result leaves `wd_flag` at 0.
- R5: With `mode_multi`=1, an out-of-range result whose entry is enabled in the mask sets status bit `res_idx` at the sampling edge. Status bits 7:0 are at address 5 and bits 9:8 at address 6 bits 1:0. Mask bits use the same layout at addresses 7 and 8. A result for a masked-off entry leaves its status bit at 0.
- R6: With the watchdog interrupt enable (control bit 1) set and the end-of-conversion interrupt enable (control bit 2) clear, a `seq_end` strobe sets `wd_flag` if any status bit is set or is being set in that cycle. `stop_req` stays 0. A `seq_end` with no status bits set leaves the flag at 0.
- R7: With control bit 1 clear, `seq_end` still sets `wd_flag` when any status bit is set, but `wd_irq` stays 0.
- R8: With control bits 1 and 2 both set in multi mode, an enabled out-of-range result sets `wd_flag` at the same edge as its status bit. At that edge `stop_req` pulses high for exactly one cycle.
- R9: `wd_irq` is high exactly while `wd_flag` and control bit 1 are both 1.
- R10: Status bits and `wd_flag` (control bit 0) are sticky. Writing 0 to a bit clears it. Writing 1 has no effect, and hardware never clears them.
- R11: When a hardware set and a software clear reach the same status bit or `wd_flag` in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| res_vld | input | 1 | Conversion result valid strobe |
| res_data | input | DATA_W | Conversion result |
| res_idx | input | IDX_W | Sequence entry or channel index of the result |
| seq_end | input | 1 | End-of-sequence strobe |
| mode_multi | input | 1 | 1: scan or buffered operation, 0: single or non-buffered continuous |
| wd_flag | output | 1 | Global watchdog flag |
| wd_status | output | N_ENT | Per-entry sticky status bits |
| wd_irq | output | 1 | Watchdog interrupt request |
| stop_req | output | 1 | One-cycle stop request to the sequencer |

## Verification
The bench builds the unit with its default parameters: ten entries and ten-bit results. With these values the status and mask fields spill over into a second byte, so entry 9 and the upper-byte lane are exercised next to the lower lane. Ten-bit bounds also make the two-byte split of each threshold observable. The upper bound is placed at 0x200 and the lower bound at 0xC5, so results exactly on each bound and one step outside it can both be driven.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int unsigned BYTE_W = 8;

    // control byte bit positions
    localparam int unsigned CB_FLAG = 0;
    localparam int unsigned CB_WIE  = 1;
    localparam int unsigned CB_EIE  = 2;
    localparam int unsigned CB_SEN  = 3;

    // fixed register addresses; status and mask follow from the entry count
    typedef enum logic [3:0] {
        RA_CTRL  = 4'd0,
        RA_HI_UP = 4'd1,
        RA_HI_LO = 4'd2,
        RA_LO_UP = 4'd3,
        RA_LO_LO = 4'd4,
        RA_STAT  = 4'd5
    } reg_addr_e;

    typedef struct packed {
        logic single_en;
        logic eoc_ie;
        logic wd_ie;
    } ctrl_t;

    function automatic int unsigned lane_bytes(input int unsigned bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/awd_cmp.sv
module awd_cmp #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] bound_hi,
    input  logic [DATA_W-1:0] bound_lo,
    output logic              out_of_band
);
    logic above;
    logic below;

    always_comb begin
        above       = value > bound_hi;
        below       = value < bound_lo;
        out_of_band = above | below;
    end
endmodule

// File: rtl/awd_regs.sv
module awd_regs
    import awd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int N_ENT  = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [N_ENT-1:0]  stat,
    input  logic              flag,
    output logic [DATA_W-1:0] bound_hi,
    output logic [DATA_W-1:0] bound_lo,
    output logic [N_ENT-1:0]  mask,
    output ctrl_t             ctrl,
    output logic              clr_flag,
    output logic [N_ENT-1:0]  clr_stat
);
    localparam int UPW       = DATA_W - 2;
    localparam int NB        = lane_bytes(N_ENT);
    localparam int STAT_BASE = int'(RA_STAT);
    localparam int MASK_BASE = STAT_BASE + NB;

    logic wr_ctrl, wr_hu, wr_hl, wr_lu, wr_ll;

    always_comb begin
        wr_ctrl = we && (addr == ADDR_W'(RA_CTRL));
        wr_hu   = we && (addr == ADDR_W'(RA_HI_UP));
        wr_hl   = we && (addr == ADDR_W'(RA_HI_LO));
        wr_lu   = we && (addr == ADDR_W'(RA_LO_UP));
        wr_ll   = we && (addr == ADDR_W'(RA_LO_LO));
        clr_flag = wr_ctrl && !wdata[CB_FLAG];
    end

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            localparam int LANE = i % BYTE_W;
            localparam int SLOT = i / BYTE_W;
            assign clr_stat[i] = we && (addr == ADDR_W'(STAT_BASE + SLOT)) && !wdata[LANE];

            always_ff @(posedge clk) begin
                if (rst)
                    mask[i] <= 1'b0;
                else if (we && (addr == ADDR_W'(MASK_BASE + SLOT)))
                    mask[i] <= wdata[LANE];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_hi <= '1;
            bound_lo <= '0;
            ctrl     <= '0;
        end else begin
            if (wr_hu) bound_hi[DATA_W-1:2] <= wdata[UPW-1:0];
            if (wr_hl) bound_hi[1:0]        <= wdata[1:0];
            if (wr_lu) bound_lo[DATA_W-1:2] <= wdata[UPW-1:0];
            if (wr_ll) bound_lo[1:0]        <= wdata[1:0];
            if (wr_ctrl) begin
                ctrl.wd_ie     <= wdata[CB_WIE];
                ctrl.eoc_ie    <= wdata[CB_EIE];
                ctrl.single_en <= wdata[CB_SEN];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(RA_CTRL): begin
                rdata[CB_FLAG] = flag;
                rdata[CB_WIE]  = ctrl.wd_ie;
                rdata[CB_EIE]  = ctrl.eoc_ie;
                rdata[CB_SEN]  = ctrl.single_en;
            end
            ADDR_W'(RA_HI_UP): rdata      = BYTE_W'(bound_hi[DATA_W-1:2]);
            ADDR_W'(RA_HI_LO): rdata[1:0] = bound_hi[1:0];
            ADDR_W'(RA_LO_UP): rdata      = BYTE_W'(bound_lo[DATA_W-1:2]);
            ADDR_W'(RA_LO_LO): rdata[1:0] = bound_lo[1:0];
            default: begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (addr == ADDR_W'(STAT_BASE + i / BYTE_W))
                        rdata[i % BYTE_W] = stat[i];
                    if (addr == ADDR_W'(MASK_BASE + i / BYTE_W))
                        rdata[i % BYTE_W] = mask[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/awd_flags.sv
module awd_flags
    import awd_pkg::*;
#(
    parameter int N_ENT = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_vld,
    input  logic [IDX_W-1:0] res_idx,
    input  logic             seq_end,
    input  logic             mode_multi,
    input  logic             oor,
    input  logic [N_ENT-1:0] mask,
    input  ctrl_t            ctrl,
    input  logic             clr_flag,
    input  logic [N_ENT-1:0] clr_stat,
    output logic [N_ENT-1:0] stat,
    output logic             flag,
    output logic             stop
);
    logic [N_ENT-1:0] hit_vec;
    logic             hit_single;
    logic             any_hit;
    logic             imm_mode;
    logic             end_set;
    logic             flag_set;

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_hit
            assign hit_vec[i] = res_vld && mode_multi && oor && mask[i]
                                && (res_idx == IDX_W'(i));
        end
    endgenerate

    always_comb begin
        hit_single = res_vld && !mode_multi && ctrl.single_en && oor;
        any_hit    = |hit_vec;
        imm_mode   = ctrl.wd_ie && ctrl.eoc_ie;
        end_set    = mode_multi && seq_end && (|(stat | hit_vec));
        flag_set   = hit_single || (mode_multi && imm_mode && any_hit) || end_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            flag <= 1'b0;
            stop <= 1'b0;
        end else begin
            stat <= (stat & ~clr_stat) | hit_vec;
            flag <= (flag & ~clr_flag) | flag_set;
            stop <= mode_multi && imm_mode && any_hit && !stop;
        end
    end
endmodule

// File: rtl/awd_unit.sv
module awd_unit
    import awd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int N_ENT  = 10,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_data,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic              seq_end,
    input  logic              mode_multi,
    output logic              wd_flag,
    output logic [N_ENT-1:0]  wd_status,
    output logic              wd_irq,
    output logic              stop_req
);
    logic [DATA_W-1:0] bound_hi, bound_lo;
    logic [N_ENT-1:0]  mask_q;
    ctrl_t             ctrl_q;
    logic              clr_flag;
    logic [N_ENT-1:0]  clr_stat;
    logic              cmp_oor;

    awd_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value      (res_data),
        .bound_hi   (bound_hi),
        .bound_lo   (bound_lo),
        .out_of_band(cmp_oor)
    );

    awd_regs #(.DATA_W(DATA_W), .N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .stat    (wd_status),
        .flag    (wd_flag),
        .bound_hi(bound_hi),
        .bound_lo(bound_lo),
        .mask    (mask_q),
        .ctrl    (ctrl_q),
        .clr_flag(clr_flag),
        .clr_stat(clr_stat)
    );

    awd_flags #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .res_vld   (res_vld),
        .res_idx   (res_idx),
        .seq_end   (seq_end),
        .mode_multi(mode_multi),
        .oor       (cmp_oor),
        .mask      (mask_q),
        .ctrl      (ctrl_q),
        .clr_flag  (clr_flag),
        .clr_stat  (clr_stat),
        .stat      (wd_status),
        .flag      (wd_flag),
        .stop      (stop_req)
    );

    assign wd_irq = wd_flag && ctrl_q.wd_ie;
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
    parameter int N_ENT = 10,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             res_vld,
    input logic [IDX_W-1:0] res_idx,
    input logic             mode_multi,
    input logic             oor,
    input logic             single_en,
    input logic             wd_ie,
    input logic             eoc_ie,
    input logic [N_ENT-1:0] mask,
    input logic [N_ENT-1:0] stat,
    input logic [N_ENT-1:0] clr_stat,
    input logic             clr_flag,
    input logic             wd_flag,
    input logic             stop_req
);
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req); // R8

    AST_STOP_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> wd_flag); // R8

    AST_DEFER_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        !(wd_ie && eoc_ie) |=> !stop_req); // R6

    AST_SINGLE_SETS: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !mode_multi && single_en && oor) |=> wd_flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wd_flag && !clr_flag) |=> wd_flag); // R10

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_bit
            AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
                (stat[i] && !clr_stat[i]) |=> stat[i]); // R10

            AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
                (res_vld && res_idx == IDX_W'(i) && !mask[i] && !stat[i]) |=> !stat[i]); // R5
        end
    endgenerate
endmodule

bind awd_unit awd_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .res_vld   (res_vld),
    .res_idx   (res_idx),
    .mode_multi(mode_multi),
    .oor       (cmp_oor),
    .single_en (ctrl_q.single_en),
    .wd_ie     (ctrl_q.wd_ie),
    .eoc_ie    (ctrl_q.eoc_ie),
    .mask      (mask_q),
    .stat      (wd_status),
    .clr_stat  (clr_stat),
    .clr_flag  (clr_flag),
    .wd_flag   (wd_flag),
    .stop_req  (stop_req)
);

// File: tb/sim_awd_unit.sv
module sim_awd_unit;
    localparam int DW = 10;
    localparam int NE = 10;
    localparam int AW = 4;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          res_vld = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [IW-1:0] res_idx = '0;
    logic          seq_end = 1'b0;
    logic          mode_multi = 1'b0;
    logic          wd_flag;
    logic [NE-1:0] wd_status;
    logic          wd_irq;
    logic          stop_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    awd_unit #(.DATA_W(DW), .N_ENT(NE), .ADDR_W(AW), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_vld(res_vld),
        .res_data(res_data), .res_idx(res_idx), .seq_end(seq_end),
        .mode_multi(mode_multi), .wd_flag(wd_flag), .wd_status(wd_status),
        .wd_irq(wd_irq), .stop_req(stop_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one clock edge, then drop strobes at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        reg_we  = 1'b0;
        res_vld = 1'b0;
        seq_end = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
        step();
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        reg_addr = AW'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic push(input int d, input int idx);
        res_vld = 1'b1; res_data = DW'(d); res_idx = IW'(idx);
        step();
    endtask

    task automatic end_seq();
        seq_end = 1'b1;
        step();
    endtask

    task automatic clear_all();
        wr(5, 0); wr(6, 0); wr(0, 0);
    endtask

    task automatic t_reset();
        rd("R1 ctrl", 0, 0);
        rd("R1 hi_up", 1, 8'hFF);
        rd("R1 hi_lo", 2, 8'h03);
        rd("R1 lo_up", 3, 0);
        rd("R1 lo_lo", 4, 0);
        rd("R1 stat_l", 5, 0);
        rd("R1 stat_h", 6, 0);
        rd("R1 mask_l", 7, 0);
        rd("R1 mask_h", 8, 0);
        chk("R1 flag", int'(wd_flag), 0);
        chk("R1 irq", int'(wd_irq), 0);
        chk("R1 stop", int'(stop_req), 0);
    endtask

    task automatic t_bounds();
        wr(1, 8'h80); wr(2, 8'h00);   // upper bound 0x200
        wr(3, 8'h31); wr(4, 8'h01);   // lower bound 0xC5
        rd("R3 hi_up", 1, 8'h80);
        rd("R3 hi_lo", 2, 8'h00);
        rd("R3 lo_up", 3, 8'h31);
        rd("R3 lo_lo", 4, 8'h01);
    endtask

    task automatic t_single();
        mode_multi = 1'b0;
        wr(0, 8'h08);
        push(12'h200, 0);
        chk("R2 equal upper", int'(wd_flag), 0);
        push(12'h0C5, 0);
        chk("R2 equal lower", int'(wd_flag), 0);
        push(12'h201, 0);
        chk("R2 R4 above upper", int'(wd_flag), 1);
        chk("R9 irq no ie", int'(wd_irq), 0);
        wr(0, 8'h08);
        chk("R10 flag cleared", int'(wd_flag), 0);
        push(12'h0C4, 0);
        chk("R2 below lower", int'(wd_flag), 1);
        wr(0, 8'h00);
        push(12'h300, 0);
        chk("R4 disabled", int'(wd_flag), 0);
        wr(0, 8'h0A);
        push(12'h300, 0);
        chk("R9 irq on", int'(wd_irq), 1);
        chk("R4 no stop", int'(stop_req), 0);
        wr(0, 8'h0A);
        chk("R9 irq off", int'(wd_irq), 0);
    endtask

    task automatic t_mask();
        mode_multi = 1'b1;
        wr(0, 8'h00);
        wr(7, 8'h05); wr(8, 8'h02);   // entries 0, 2, 9
        rd("R5 mask_l", 7, 8'h05);
        rd("R5 mask_h", 8, 8'h02);
        push(12'h300, 1);
        rd("R5 masked", 5, 0);
        push(12'h300, 2);
        rd("R5 entry2", 5, 8'h04);
        push(12'h300, 9);
        rd("R5 entry9", 6, 8'h02);
        push(12'h100, 0);
        rd("R5 in range", 5, 8'h04);
        chk("R7 no flag before end", int'(wd_flag), 0);
        end_seq();
        chk("R7 flag at end", int'(wd_flag), 1);
        chk("R7 no irq", int'(wd_irq), 0);
        clear_all();
        chk("R10 stat cleared", int'(wd_status), 0);
    endtask

    task automatic t_defer();
        wr(0, 8'h02);
        push(12'h300, 2);
        chk("R6 not yet", int'(wd_flag), 0);
        chk("R6 no stop", int'(stop_req), 0);
        end_seq();
        chk("R6 flag at end", int'(wd_flag), 1);
        chk("R6 irq", int'(wd_irq), 1);
        clear_all();
        wr(0, 8'h02);
        end_seq();
        chk("R6 empty end", int'(wd_flag), 0);
    endtask

    task automatic t_imm();
        wr(0, 8'h06);
        push(12'h300, 9);
        chk("R8 flag now", int'(wd_flag), 1);
        chk("R8 stop pulse", int'(stop_req), 1);
        chk("R8 irq", int'(wd_irq), 1);
        step();
        chk("R8 stop one cycle", int'(stop_req), 0);
    endtask

    task automatic t_sticky();
        wr(0, 8'h07);                 // writing 1 to the flag keeps it
        chk("R10 flag write1", int'(wd_flag), 1);
        wr(6, 8'hFF);
        chk("R10 stat write1", int'(wd_status), 10'h200);
        wr(5, 8'h00);
        chk("R10 other byte", int'(wd_status), 10'h200);
        clear_all();
        chk("R10 all clear", int'(wd_status), 0);
    endtask

    task automatic t_race();
        wr(0, 8'h00);
        push(12'h300, 2);
        reg_we = 1'b1; reg_addr = AW'(5); reg_wdata = 8'h00;
        res_vld = 1'b1; res_data = DW'(12'h300); res_idx = IW'(2);
        step();
        chk("R11 stat set wins", int'(wd_status), 10'h004);
        mode_multi = 1'b0;
        wr(0, 8'h08);
        push(12'h300, 0);
        reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 8'h08;
        res_vld = 1'b1; res_data = DW'(12'h300);
        step();
        chk("R11 flag set wins", int'(wd_flag), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bounds();
        t_single();
        t_mask();
        t_defer();
        t_imm();
        t_sticky();
        t_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule